// File: doc/BRIEF.md
# Reservation Tracker for Load-Reserve / Store-Conditional Pairs

This block holds the single atomic reservation of a 32-bit in-order core's data side. A reserving load arms the reservation and records the word it targets. A later conditional store compares its own word against that record. It writes memory only when the two agree and the reservation is armed. It then returns a 4-bit condition field and disarms the reservation.

The conditional store runs as two pieces. The first piece occupies one cycle. It performs the permission check and, when allowed, drives the memory write port. The second piece may be stalled for any number of cycles. When it completes, it publishes the condition field and clears the reservation. Asynchronous interrupts use a request/accept handshake. The block refuses to accept an interrupt while the second piece is outstanding, so a memory write can never be separated from its condition update. An interrupt that arrives before the first piece commits squashes the whole store.

Top module: `lrsc_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `rsv_valid`, `mem_we`, `cr0_valid`, `sc_fault` and `irq_ack` are 0, `rsv_word` is 0, and `op_ready` is 1 when `irq_req` is 0.
- R2: `op_kind` 2'b01 is a reserving load. When accepted, it sets `rsv_valid` to 1 and `rsv_word` to `op_addr[31:2]` at the next clock edge. Kinds 2'b00 and 2'b11 are accepted without effect on any output. Kind 2'b10 is a conditional store.
- R3: `op_ready` is 1 exactly when no conditional store is in progress and `irq_req` is 0. An operation is taken on an edge where `op_valid` and `op_ready` are both 1.
- R4: The first piece occupies the cycle after a conditional store is taken. In that cycle, with permission, no interrupt, `rsv_valid` set and `rsv_word` equal to the store's `op_addr[31:2]`, `mem_we` is 1 with the store's address and data.
- R5: A conditional store whose word differs from `rsv_word`, or that finds `rsv_valid` at 0, does not write memory and reports EQ=0.
- R6: A conditional store without write permission pulses `sc_fault` in its first-piece cycle. It does not write, produces no condition field, and leaves the reservation unchanged.
- R7: `cr0_field` is {LT,GT,EQ,SO} in bits 3..0. LT and GT are 0, EQ is 1 when the store wrote memory, and SO is `so_flag` as sampled when the store was taken. The field is valid for one cycle, which is the first cycle of the second piece where `p2_stall` is 0.
- R8: On the edge that ends the second piece, `rsv_valid` drops to 0, whether the store succeeded or failed.
- R9: While `p2_stall` is 1, the second piece holds. It produces no condition field and the reservation is not cleared.
- R10: `irq_ack` equals `irq_req` except while a second piece is outstanding, when it is 0. A memory write is therefore never followed by an accepted interrupt before its condition field appears.
- R11: An interrupt accepted in the first-piece cycle squashes the store: no write, no fault, no condition field. `op_ready` returns on the next cycle.
- R12: An accepted interrupt never changes `rsv_valid` or `rsv_word` at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_kind | input | 2 | 01 reserving load, 10 conditional store, others no effect |
| op_addr | input | 32 | Byte address of the operation |
| op_wdata | input | 32 | Store data |
| op_wperm | input | 1 | Write permission for the conditional store |
| so_flag | input | 1 | Sticky overflow copied into the condition field |
| op_ready | output | 1 | Block can take an operation this cycle |
| p2_stall | input | 1 | Holds the second piece in execute |
| irq_req | input | 1 | Asynchronous interrupt request |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| cr0_valid | output | 1 | Condition field valid |
| cr0_field | output | 4 | {LT,GT,EQ,SO} |
| sc_fault | output | 1 | Storage exception on the conditional store |
| rsv_valid | output | 1 | Reservation armed |
| rsv_word | output | 30 | Reserved word address |

## Verification
The assertions check the following on every cycle:
- no write happens without an armed reservation;
- no interrupt is accepted during the second piece or alongside a write;
- a completed second piece always disarms the reservation;
- an accepted interrupt never disturbs the reservation;
- a stalled second piece stays put.

Other properties depend on the order and timing of requests and are shown only by the bench's scenarios: matching the reserved word, latching the overflow bit, squashing on an interrupt before commit, and pairing every write with a success code. The bench sweeps interrupt timing across each cycle offset around a conditional store, with several stall lengths.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int unsigned LRSC_ADDR_W = 32;
    localparam int unsigned LRSC_DATA_W = 32;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_LRSV  = 2'b01,
        OP_SCOND = 2'b10,
        OP_RSVD  = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'b00,
        SQ_FIRST  = 2'b01,
        SQ_SECOND = 2'b10
    } sq_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_field_t;

    function automatic cond_field_t make_cond(input logic ok, input logic so);
        cond_field_t c;
        c.lt = 1'b0;
        c.gt = 1'b0;
        c.eq = ok;
        c.so = so;
        return c;
    endfunction

    function automatic int unsigned byte_offs_bits(input int unsigned data_w);
        return $clog2(data_w / 8);
    endfunction

endpackage

// File: rtl/lrsc_rsv_reg.sv
module lrsc_rsv_reg #(
    parameter int unsigned WORD_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [WORD_W-1:0] set_word,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] probe_word,
    output logic              valid,
    output logic [WORD_W-1:0] word,
    output logic              hit
);
    logic              valid_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (set_en) begin
            valid_q <= 1'b1;
            word_q  <= set_word;
        end else if (clr_en) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign word  = word_q;
    assign hit   = valid_q && (word_q == probe_word);

    // R2: an arming load always leaves the reservation armed
    p_set_arms_r2: assert property (@(posedge clk) disable iff (rst)
        set_en |=> valid_q);

    // R8: a clear without a simultaneous set disarms
    p_clear_disarms_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> !valid_q);

endmodule

// File: rtl/lrsc_irq_gate.sv
module lrsc_irq_gate (
    input  logic irq_req,
    input  logic hold,
    output logic irq_ack
);
    assign irq_ack = irq_req && !hold;
endmodule

// File: rtl/lrsc_sc_seq.sv
module lrsc_sc_seq
    import lrsc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned OFFS   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [1:0]           op_kind,
    input  logic [ADDR_W-1:0]    op_addr,
    input  logic [DATA_W-1:0]    op_wdata,
    input  logic                 op_wperm,
    input  logic                 so_flag,
    input  logic                 p2_stall,
    input  logic                 irq_req,
    input  logic                 irq_ack,
    input  logic                 rsv_hit,
    output logic                 op_ready,
    output logic                 lr_set,
    output logic [ADDR_W-OFFS-1:0] lr_word,
    output logic [ADDR_W-OFFS-1:0] probe_word,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 cr0_valid,
    output cond_field_t          cr0_field,
    output logic                 sc_fault,
    output logic                 rsv_clr,
    output logic                 second_pending
);
    sq_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              perm_q, so_q, ok_q;
    op_kind_e          kind;
    logic              take, first_live;

    assign kind       = op_kind_e'(op_kind);
    assign op_ready   = (state_q == SQ_IDLE) && !irq_req;
    assign take       = op_valid && op_ready;
    assign lr_set     = take && (kind == OP_LRSV);
    assign lr_word    = op_addr[ADDR_W-1:OFFS];
    assign probe_word = addr_q[ADDR_W-1:OFFS];

    assign first_live     = (state_q == SQ_FIRST) && !irq_ack;
    assign mem_we         = first_live && perm_q && rsv_hit;
    assign sc_fault       = first_live && !perm_q;
    assign mem_addr       = addr_q;
    assign mem_wdata      = data_q;
    assign second_pending = (state_q == SQ_SECOND);
    assign cr0_valid      = second_pending && !p2_stall;
    assign cr0_field      = make_cond(ok_q, so_q);
    assign rsv_clr        = cr0_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (take && kind == OP_SCOND) state_d = SQ_FIRST;
            SQ_FIRST:  if (irq_ack || !perm_q) state_d = SQ_IDLE;
                       else state_d = SQ_SECOND;
            SQ_SECOND: if (!p2_stall) state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            perm_q  <= 1'b0;
            so_q    <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take && kind == OP_SCOND) begin
                addr_q <= op_addr;
                data_q <= op_wdata;
                perm_q <= op_wperm;
                so_q   <= so_flag;
            end
            if (state_q == SQ_FIRST) ok_q <= mem_we;
        end
    end

    // R10: no interrupt accepted while the second piece is outstanding
    p_second_blocks_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_SECOND) |-> !irq_ack);

    // R9: a stalled second piece stays in place
    p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_SECOND && p2_stall) |=> (state_q == SQ_SECOND));

    // R7: LT and GT never set in a published field
    p_cond_shape_r7: assert property (@(posedge clk) disable iff (rst)
        cr0_valid |-> (!cr0_field.lt && !cr0_field.gt));

    // R11: an interrupt in the first piece returns to idle
    p_squash_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_FIRST && irq_ack) |=> (state_q == SQ_IDLE));

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int unsigned ADDR_W = LRSC_ADDR_W,
    parameter int unsigned DATA_W = LRSC_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic              op_wperm,
    input  logic              so_flag,
    output logic              op_ready,
    input  logic              p2_stall,
    input  logic              irq_req,
    output logic              irq_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              cr0_valid,
    output logic [3:0]        cr0_field,
    output logic              sc_fault,
    output logic              rsv_valid,
    output logic [ADDR_W-byte_offs_bits(DATA_W)-1:0] rsv_word
);
    localparam int unsigned OFFS   = byte_offs_bits(DATA_W);
    localparam int unsigned WORD_W = ADDR_W - OFFS;

    logic              lr_set, rsv_clr, rsv_hit, second_pending;
    logic [WORD_W-1:0] lr_word, probe_word;
    cond_field_t       cond;

    lrsc_irq_gate u_gate (
        .irq_req (irq_req),
        .hold    (second_pending),
        .irq_ack (irq_ack)
    );

    lrsc_rsv_reg #(.WORD_W(WORD_W)) u_rsv (
        .clk        (clk),
        .rst        (rst),
        .set_en     (lr_set),
        .set_word   (lr_word),
        .clr_en     (rsv_clr),
        .probe_word (probe_word),
        .valid      (rsv_valid),
        .word       (rsv_word),
        .hit        (rsv_hit)
    );

    lrsc_sc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS(OFFS)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .op_valid       (op_valid),
        .op_kind        (op_kind),
        .op_addr        (op_addr),
        .op_wdata       (op_wdata),
        .op_wperm       (op_wperm),
        .so_flag        (so_flag),
        .p2_stall       (p2_stall),
        .irq_req        (irq_req),
        .irq_ack        (irq_ack),
        .rsv_hit        (rsv_hit),
        .op_ready       (op_ready),
        .lr_set         (lr_set),
        .lr_word        (lr_word),
        .probe_word     (probe_word),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .cr0_valid      (cr0_valid),
        .cr0_field      (cond),
        .sc_fault       (sc_fault),
        .rsv_clr        (rsv_clr),
        .second_pending (second_pending)
    );

    assign cr0_field = cond;

    // R4: a memory write requires an armed reservation
    p_write_needs_rsv_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> rsv_valid);

    // R10: a write cycle never accepts an interrupt
    p_write_no_irq_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !irq_ack);

    // R8: a published condition field disarms the reservation
    p_cond_clears_r8: assert property (@(posedge clk) disable iff (rst)
        cr0_valid |=> !rsv_valid);

    // R12: an accepted interrupt leaves the reservation untouched
    p_irq_keeps_rsv_r12: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> ($stable(rsv_valid) && $stable(rsv_word)));

    // R6: a fault and a write never coincide
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && sc_fault));

endmodule

// File: tb/lrsc_unit_tb_top.sv
module lrsc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, op_wperm, so_flag, p2_stall, irq_req;
    logic [1:0]  op_kind;
    logic [31:0] op_addr, op_wdata;
    logic        op_ready, irq_ack, mem_we, cr0_valid, sc_fault, rsv_valid;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  cr0_field;
    logic [29:0] rsv_word;

    always #10 clk = ~clk;

    lrsc_unit dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_wdata(op_wdata), .op_wperm(op_wperm),
        .so_flag(so_flag), .op_ready(op_ready), .p2_stall(p2_stall),
        .irq_req(irq_req), .irq_ack(irq_ack), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cr0_valid(cr0_valid),
        .cr0_field(cr0_field), .sc_fault(sc_fault), .rsv_valid(rsv_valid),
        .rsv_word(rsv_word)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int          m_phase = 0;
    bit          m_rv = 0;
    logic [29:0] m_rw = '0;
    logic [31:0] m_addr = '0, m_data = '0;
    bit          m_perm = 0, m_so = 0, m_ok = 0;
    bit          pend_wr = 0, want_clear = 0;
    int          st_left = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        bit e_ready, e_ack, e_we, e_fault, e_crv, match;
        #1;
        if (want_clear) begin
            chk("R8 reservation cleared after success", rsv_valid, 0);
            want_clear = 0;
        end
        match   = m_rv && (m_rw == m_addr[31:2]);
        e_ready = (m_phase == 0) && !irq_req;
        e_ack   = irq_req && (m_phase != 2);
        e_we    = (m_phase == 1) && !irq_req && m_perm && match;
        e_fault = (m_phase == 1) && !irq_req && !m_perm;
        e_crv   = (m_phase == 2) && !p2_stall;
        chk("R3 op_ready", op_ready, e_ready);
        chk("R10 irq_ack", irq_ack, e_ack);
        chk("R4 mem_we", mem_we, e_we);
        if (e_we) begin
            chk("R4 mem_addr", mem_addr, m_addr);
            chk("R4 mem_wdata", mem_wdata, m_data);
        end
        chk("R6 sc_fault", sc_fault, e_fault);
        chk("R7 cr0_valid", cr0_valid, e_crv);
        if (e_crv) chk("R7 cr0_field", cr0_field, {2'b00, m_ok, m_so});
        chk("R8 rsv_valid", rsv_valid, m_rv);
        chk("R2 rsv_word", rsv_word, m_rw);
        // pairing of a write with its condition field
        if (mem_we) pend_wr = 1;
        if (pend_wr && irq_ack) begin
            errors++; checks++;
            $display("FAIL R10 irq accepted after write actual=1 expected=0");
        end
        if (pend_wr && cr0_valid) begin
            chk("R4 write paired with EQ=1", cr0_field[1], 1);
            pend_wr = 0;
            want_clear = 1;
        end
        @(posedge clk);
        if (m_phase == 0) begin
            if (op_valid && e_ready) begin
                if (op_kind == 2'b01) begin
                    m_rv = 1; m_rw = op_addr[31:2];
                end else if (op_kind == 2'b10) begin
                    m_phase = 1; m_addr = op_addr; m_data = op_wdata;
                    m_perm = op_wperm; m_so = so_flag;
                end
            end
        end else if (m_phase == 1) begin
            if (irq_req || !m_perm) m_phase = 0;
            else begin m_ok = match; m_phase = 2; end
        end else if (!p2_stall) begin
            m_rv = 0; m_phase = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        op_valid = 0; irq_req = 0; p2_stall = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic issue(input logic [1:0] k, input logic [31:0] a);
        op_valid = 1; op_kind = k; op_addr = a;
        tick();
        op_valid = 0;
    endtask

    task automatic run_sc(input logic [31:0] a, input logic [31:0] d, input bit perm,
                          input bit so, input int irq_at, input int irq_len, input int stall);
        bit accepted = 0;
        st_left = stall;
        for (int c = 0; c < 12; c++) begin
            op_valid = !accepted; op_kind = 2'b10; op_addr = a; op_wdata = d;
            op_wperm = perm; so_flag = so;
            irq_req  = (c >= irq_at) && (c < irq_at + irq_len);
            p2_stall = (m_phase == 2) && (st_left > 0);
            if (p2_stall) st_left--;
            if (op_valid && m_phase == 0 && !irq_req) accepted = 1;
            tick();
        end
        op_valid = 0; irq_req = 0; p2_stall = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; op_valid = 0; op_kind = 0; op_addr = 0; op_wdata = 0;
        op_wperm = 1; so_flag = 0; p2_stall = 0; irq_req = 0;
        repeat (3) @(negedge clk);
        // R1: reset values while reset is still high
        chk("R1 rsv_valid in reset", rsv_valid, 0);
        chk("R1 mem_we in reset", mem_we, 0);
        chk("R1 irq_ack in reset", irq_ack, 0);
        rst = 0;
        #1;
        chk("R1 op_ready after reset", op_ready, 1);
        chk("R1 cr0_valid after reset", cr0_valid, 0);
        @(negedge clk);
        idle(2);

        // R2 R4 R7: armed reservation, matching store succeeds
        issue(2'b01, 32'h0000_1000);
        run_sc(32'h0000_1000, 32'hCAFE_0001, 1, 1, 99, 0, 0);
        // R5: reservation gone, same store fails
        run_sc(32'h0000_1000, 32'hCAFE_0002, 1, 0, 99, 0, 0);
        // R5: different word fails
        issue(2'b01, 32'h0000_2000);
        run_sc(32'h0000_2004, 32'hCAFE_0003, 1, 0, 99, 0, 0);
        // same word, different byte offset succeeds
        issue(2'b01, 32'h0000_3000);
        run_sc(32'h0000_3002, 32'hCAFE_0004, 1, 0, 99, 0, 0);
        // R6: no permission keeps reservation
        issue(2'b01, 32'h0000_4000);
        run_sc(32'h0000_4000, 32'hCAFE_0005, 0, 0, 99, 0, 0);
        chk("R6 reservation kept after fault", rsv_valid, 1);
        run_sc(32'h0000_4000, 32'hCAFE_0006, 1, 0, 99, 0, 1);
        // R2: kinds 00 and 11 have no effect
        issue(2'b01, 32'h0000_5000);
        issue(2'b00, 32'h0000_6000);
        issue(2'b11, 32'h0000_7000);
        chk("R2 ignored kinds keep word", rsv_word, 30'h0000_5000 >> 2);
        // R9 R10: stalled second piece with interrupt pending
        run_sc(32'h0000_5000, 32'hCAFE_0007, 1, 1, 2, 5, 3);
        // R12: idle interrupt keeps reservation
        issue(2'b01, 32'h0000_8000);
        irq_req = 1; tick(); tick(); irq_req = 0;
        chk("R12 reservation after idle irq", rsv_valid, 1);
        idle(1);
        // R11 R10 R12: interrupt at every offset, lengths and stalls
        for (int off = 0; off < 7; off++)
            for (int len = 1; len < 3; len++)
                for (int st = 0; st < 3; st++) begin
                    issue(2'b01, 32'h0001_0000 + off * 16);
                    run_sc(32'h0001_0000 + off * 16, 32'h1234_0000 + off, 1, st[0], off, len, st);
                    idle(1);
                end
        idle(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule